// File: doc/BRIEF.md
# UART Receive Buffer and Line Status

This block sits between the receive shift register of a 16550-style UART and the CPU-side register file. Each completed character arrives as a one-cycle strobe with a data byte and two error tags: a parity error, and a framing error (the stop bit was sampled as 0). The block stores the character together with its tags. When the FIFO-enable control is low, storage is a single holding register. When it is high, storage is a 16-entry receive FIFO.

The CPU reads the receive buffer through a read strobe. The buffer output always shows the oldest unread character. Status comes from a 4-bit line status value:
- bit 0 is data-ready;
- bit 1 is overrun;
- bit 2 is parity error;
- bit 3 is framing error.

The error bits describe the character at the head of the storage. They are sticky until the status is read. A character that arrives when storage is full is dropped; it never overwrites stored data.

Top module: `uart_rx_stat`

## Requirements
- R1: After reset, the status output is 4'b0000 and the buffer output is 8'h00.
- R2: With FIFO mode enabled, up to 16 characters are held. The buffer output shows the oldest unread character, and each read strobe advances to the next one in arrival order.
- R3: Status bit 0 (data-ready) is 1 from the cycle after a character is stored until the cycle after the last stored character is read.
- R4: In FIFO mode, a character that arrives while 16 characters are stored sets status bit 1 (overrun). That character is discarded and the stored contents are unchanged.
- R5: With FIFO mode disabled, one character is held. A second character that arrives before the first is read sets bit 1 and is discarded, and the first character is kept.
- R6: Bit 2 (parity) and bit 3 (framing) are loaded from the tags of each character as it becomes the oldest stored one. Once set, they stay set when a later, clean character becomes the oldest.
- R7: A status read strobe clears bits 1, 2 and 3 in the following cycle and leaves bit 0 unaffected.
- R8: When an error event and a status read occur in the same cycle, the affected bit is 1 afterwards.
- R9: A buffer read with nothing stored leaves the buffer output at the last value read and moves no pointer. A character stored afterwards is read back correctly.
- R10: Changing the FIFO-enable input discards all stored characters. Bit 0 is 0 in the following cycle, and a character strobed in that same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1 selects 16-entry FIFO, 0 selects single holding register |
| chr_vld | input | 1 | One-cycle strobe: a character has completed |
| chr_data | input | 8 | Completed character |
| chr_perr | input | 1 | Parity-error tag of the completed character |
| chr_ferr | input | 1 | Framing-error tag of the completed character |
| buf_rd | input | 1 | Read strobe of the receive buffer |
| stat_rd | input | 1 | Read strobe of the line status |
| buf_q | output | 8 | Oldest unread character, or last value read when empty |
| stat_q | output | 4 | {framing, parity, overrun, data-ready} |

## Verification
The hardest situations to reach are collisions at the edges of the storage. Examples are a status read in the very cycle an error arrives, and a character strobed in the cycle the mode changes. The bench produces these by driving the colliding strobes on the same falling edge. In FIFO mode it first fills all sixteen entries, so that the seventeenth character meets a full FIFO. It then checks that this character is absent from the sixteen values read back against the scoreboard.

// File: rtl/rxs_pkg.sv
// Package: shared entry type and sizes of the receive buffer.
// Assumes a byte-wide character and two per-character error tags.
package rxs_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;
endpackage

// File: rtl/rxs_mode.sv
// Mode tracker: registers the FIFO-enable input and pulses a flush for one
// cycle whenever it changes. Assumes fifo_en is synchronous to clk.
module rxs_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_en,
    output logic fifo_en_q,
    output logic flush
);
    // Register the mode so that a change can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) fifo_en_q <= 1'b0;
        else        fifo_en_q <= fifo_en;
    end

    // A flush is requested in the cycle the input differs from its registered copy.
    always_comb flush = (fifo_en != fifo_en_q);
endmodule

// File: rtl/rxs_store.sv
// Character storage: circular buffer of DEPTH tagged entries. Its usable
// capacity is DEPTH in FIFO mode and 1 in holding-register mode. It reports
// overrun attempts and the tags of each entry as it becomes the head.
// Assumes DEPTH >= 2 and at most one strobe of each kind per cycle.
module rxs_store
    import rxs_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode,
    input  logic              flush,
    input  logic              wr,
    input  rx_entry_t         wr_ent,
    input  logic              rd,
    output logic [DATA_W-1:0] rd_data,
    output logic              not_empty,
    output logic              ovr_evt,
    output logic              head_new,
    output logic              head_perr,
    output logic              head_ferr
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    rx_entry_t         mem [DEPTH];
    logic [AW-1:0]     wp, rp, rp_nx, wp_nx;
    logic [CW-1:0]     cnt, cap;
    logic              full, push, pop;
    logic [DATA_W-1:0] last_q;

    // Capacity follows the registered mode.
    always_comb cap = fifo_mode ? CW'(DEPTH) : CW'(1);

    // Occupancy and accepted operations; a flush blocks both.
    always_comb begin
        full    = (cnt >= cap);
        push    = wr && !full && !flush;
        pop     = rd && (cnt != '0) && !flush;
        ovr_evt = wr && full && !flush;
        rp_nx   = (rp == LAST) ? '0 : rp + 1'b1;
        wp_nx   = (wp == LAST) ? '0 : wp + 1'b1;
    end

    // Head-change detection and the tags of the new head.
    always_comb begin
        head_new = push && (cnt == '0) || pop && ((cnt > CW'(1)) || push);
        if (cnt > CW'(1)) begin
            head_perr = mem[rp_nx].perr;
            head_ferr = mem[rp_nx].ferr;
        end else begin
            head_perr = wr_ent.perr;
            head_ferr = wr_ent.ferr;
        end
    end

    // Write the storage array (no reset needed for data).
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wr_ent;
    end

    // Advance pointers and the occupancy count, or clear them on flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp_nx;
            if (pop)  rp <= rp_nx;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Remember the value of the last read so that an empty read repeats it.
    always_ff @(posedge clk) begin
        if (!rst_n)   last_q <= '0;
        else if (pop) last_q <= mem[rp].data;
    end

    // Buffer output: the head when stored data exists, else the last value read.
    always_comb begin
        not_empty = (cnt != '0);
        rd_data   = not_empty ? mem[rp].data : last_q;
    end

    // R2 / R4: occupancy never exceeds the depth.
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    // R5: holding-register mode never holds more than one character.
    p_hold_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |-> cnt <= CW'(1));
    // R10: a flush empties the storage.
    p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> cnt == '0);
    // R9: an empty read does not move the read pointer.
    p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && cnt == '0 && !flush) |=> $stable(rp));
endmodule

// File: rtl/rxs_status.sv
// Line-status error bits: overrun, parity and framing. Each bit is set by
// its event, cleared by a status read, and the event wins over the read.
// Assumes the event inputs are single-cycle qualified pulses.
module rxs_status (
    input  logic clk,
    input  logic rst_n,
    input  logic ovr_evt,
    input  logic head_new,
    input  logic head_perr,
    input  logic head_ferr,
    input  logic stat_rd,
    output logic oe,
    output logic pe,
    output logic fe
);
    logic set_pe, set_fe;

    // Error bits latch from a new head entry's tags.
    always_comb begin
        set_pe = head_new && head_perr;
        set_fe = head_new && head_ferr;
    end

    // Sticky error bits with read-clear; a set in the same cycle has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe <= 1'b0;
            pe <= 1'b0;
            fe <= 1'b0;
        end else begin
            oe <= ovr_evt ? 1'b1 : (stat_rd ? 1'b0 : oe);
            pe <= set_pe  ? 1'b1 : (stat_rd ? 1'b0 : pe);
            fe <= set_fe  ? 1'b1 : (stat_rd ? 1'b0 : fe);
        end
    end

    // R8: an overrun event leaves the bit set even with a concurrent read.
    p_oe_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> oe);
    // R7: a read with no concurrent event clears the overrun bit.
    p_rd_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !ovr_evt) |=> !oe);
    // R6: a clean head without a read cannot clear a set parity bit.
    p_pe_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pe && !stat_rd) |=> pe);
endmodule

// File: rtl/uart_rx_stat.sv
// Top of the receive buffer and line status: tracks the mode, stores tagged
// characters and maintains the 4-bit status {fe, pe, oe, dr}.
// Assumes single-cycle strobes from the shift register and the CPU side.
module uart_rx_stat
    import rxs_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              chr_vld,
    input  logic [DATA_W-1:0] chr_data,
    input  logic              chr_perr,
    input  logic              chr_ferr,
    input  logic              buf_rd,
    input  logic              stat_rd,
    output logic [DATA_W-1:0] buf_q,
    output logic [3:0]        stat_q
);
    logic      mode_q, flush, dr, ovr_evt, head_new, head_perr, head_ferr;
    logic      oe, pe, fe;
    rx_entry_t in_ent;

    // Pack the incoming character with its tags.
    always_comb in_ent = '{ferr: chr_ferr, perr: chr_perr, data: chr_data};

    rxs_mode u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (fifo_en),
        .fifo_en_q (mode_q),
        .flush     (flush)
    );

    rxs_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_mode (mode_q),
        .flush     (flush),
        .wr        (chr_vld),
        .wr_ent    (in_ent),
        .rd        (buf_rd),
        .rd_data   (buf_q),
        .not_empty (dr),
        .ovr_evt   (ovr_evt),
        .head_new  (head_new),
        .head_perr (head_perr),
        .head_ferr (head_ferr)
    );

    rxs_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovr_evt   (ovr_evt),
        .head_new  (head_new),
        .head_perr (head_perr),
        .head_ferr (head_ferr),
        .stat_rd   (stat_rd),
        .oe        (oe),
        .pe        (pe),
        .fe        (fe)
    );

    // Assemble the line status output.
    always_comb stat_q = {fe, pe, oe, dr};

    // R3: data-ready drops after a read of the only stored character.
    p_dr_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dr && buf_rd && !chr_vld && !flush && $past(!dr)) |=> !dr);
endmodule

// File: tb/sim_uart_rx_stat.sv
// Scoreboard bench: the driver pushes expected characters into a queue,
// and the read monitor pops and compares them against the buffer output.
module sim_uart_rx_stat;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic       chr_vld = 1'b0;
    logic [7:0] chr_data = 8'h00;
    logic       chr_perr = 1'b0;
    logic       chr_ferr = 1'b0;
    logic       buf_rd = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] buf_q;
    logic [3:0] stat_q;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q [$];

    always #5 clk = ~clk;

    uart_rx_stat u0 (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .chr_vld(chr_vld),
        .chr_data(chr_data), .chr_perr(chr_perr), .chr_ferr(chr_ferr),
        .buf_rd(buf_rd), .stat_rd(stat_rd), .buf_q(buf_q), .stat_q(stat_q)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver: one character strobe; expected data queued when it should be kept.
    task automatic send(input logic [7:0] d, input bit pe, input bit fe, input bit keep);
        @(negedge clk);
        chr_vld = 1'b1; chr_data = d; chr_perr = pe; chr_ferr = fe;
        @(negedge clk);
        chr_vld = 1'b0; chr_perr = 1'b0; chr_ferr = 1'b0;
        if (keep) exp_q.push_back(d);
    endtask

    // Monitor: pop the scoreboard and compare with the buffer before reading.
    task automatic pop_chk(input string req);
        logic [7:0] e;
        e = exp_q.pop_front();
        @(negedge clk);
        chk(buf_q == e, req, buf_q, e);
        buf_rd = 1'b1;
        @(negedge clk);
        buf_rd = 1'b0;
    endtask

    task automatic stat_read();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic stat_chk(input logic [3:0] e, input string req);
        chk(stat_q == e, req, stat_q, e);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset state
        stat_chk(4'b0000, "R1 status");
        chk(buf_q == 8'h00, "R1 buffer", buf_q, 0);

        // R2/R3: a few characters in order
        send(8'h11, 0, 0, 1);
        stat_chk(4'b0001, "R3 data-ready set");
        send(8'h22, 0, 0, 1);
        send(8'h33, 0, 0, 1);
        repeat (3) pop_chk("R2 order");
        @(negedge clk);
        stat_chk(4'b0000, "R3 data-ready clear");

        // R4: fill sixteen, seventeenth dropped
        for (int i = 0; i < 16; i++) send(8'h40 + 8'(i), 0, 0, 1);
        send(8'hEE, 0, 0, 0);
        stat_chk(4'b0011, "R4 overrun");
        stat_read();
        stat_chk(4'b0001, "R7 read clears, dr kept");
        for (int i = 0; i < 16; i++) pop_chk("R4 contents");
        stat_chk(4'b0000, "R4 empty after drain");

        // R6: parity sticky while head advances; R7 clear
        send(8'h51, 1, 0, 1);
        stat_chk(4'b0101, "R6 parity from head");
        send(8'h52, 0, 0, 1);
        pop_chk("R6 first");
        stat_chk(4'b0101, "R6 parity sticky");
        stat_read();
        stat_chk(4'b0001, "R7 parity cleared");
        pop_chk("R6 second");
        send(8'h53, 0, 1, 1);
        stat_chk(4'b1001, "R6 framing from head");
        stat_read();
        stat_chk(4'b0001, "R7 framing cleared");
        pop_chk("R6 third");

        // R8: parity event collides with status read
        @(negedge clk);
        chr_vld = 1'b1; chr_data = 8'h61; chr_perr = 1'b1; stat_rd = 1'b1;
        @(negedge clk);
        chr_vld = 1'b0; chr_perr = 1'b0; stat_rd = 1'b0;
        exp_q.push_back(8'h61);
        stat_chk(4'b0101, "R8 parity wins");
        stat_read();
        pop_chk("R8 data");

        // R9: empty read repeats last value
        @(negedge clk);
        buf_rd = 1'b1;
        @(negedge clk);
        buf_rd = 1'b0;
        chk(buf_q == 8'h61, "R9 last value", buf_q, 8'h61);
        stat_chk(4'b0000, "R9 still empty");
        send(8'h62, 0, 0, 1);
        pop_chk("R9 pointer intact");
        stat_chk(4'b0000, "R9 empty again");

        // R10: mode change flushes; strobe in that cycle discarded
        send(8'h71, 0, 0, 0);
        @(negedge clk);
        fifo_en = 1'b0; chr_vld = 1'b1; chr_data = 8'h72;
        @(negedge clk);
        chr_vld = 1'b0;
        stat_chk(4'b0000, "R10 flushed");

        // R5: holding register, second character dropped
        send(8'h81, 0, 0, 1);
        send(8'h82, 0, 0, 0);
        stat_chk(4'b0011, "R5 overrun");
        chk(buf_q == 8'h81, "R5 first kept", buf_q, 8'h81);
        // R8: overrun collides with status read
        @(negedge clk);
        chr_vld = 1'b1; chr_data = 8'h83; stat_rd = 1'b1;
        @(negedge clk);
        chr_vld = 1'b0; stat_rd = 1'b0;
        stat_chk(4'b0011, "R8 overrun wins");
        pop_chk("R5 read first");
        stat_chk(4'b0010, "R5 dr clear");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule